// File: doc/BRIEF.md
# Host-Firmware Mailbox With Ownership

This block is a message mailbox shared by a host bus and an embedded firmware agent. It holds a data area of `NUM_WORDS` words of `WORD_W` bits. The default is eight 64-bit words, or 64 bytes. Next to the data area sits a control word that carries an owner field, a message-valid flag and a sticky busy flag. The owner field decides who may load the data area. The host can write data words only while it owns the mailbox.

A typical exchange runs as follows:
- The host claims an idle mailbox and fills in the message.
- The host hands the message over with a single control write that sets owner to firmware and sets message-valid.
- Firmware sees an interrupt, reads the words through its own read port, and pulses `fw_release`. This gives the mailbox back to the host and clears message-valid.

A read-only copy of the control word can be read at a second address.

Host word addresses:
- Index 0 to `NUM_WORDS-1` selects a data word.
- Index `NUM_WORDS` selects the control word. It sits directly after the data area.
- Index `NUM_WORDS+1` selects the read-only copy.

Control word bit layout:
- Bits [1:0] hold the owner field, encoded 0 = none, 1 = firmware, 2 = host, 3 = reserved.
- Bit 4 holds message-valid.
- Bit 5 holds busy.
- All other bits read 0.

Top module: `hfmb_top`

## Requirements
- R1: After reset the owner is none (0), message-valid and busy are 0, all data words read 0 and `fw_irq` is low.
- R2: While the owner is host (2), a host write to data index i stores the value, which is then read back at host index i.
- R3: A host data write while the owner is not host leaves every data word unchanged and sets busy (control bit 5), which stays set.
- R4: A host control write with bit 5 set clears busy, whatever the owner.
- R5: With the owner none, a host control write with owner code 2 makes the host the owner, and a `fw_claim` pulse makes firmware the owner. If both occur in the same cycle, firmware wins.
- R6: With the owner host, a control write of owner 1 with bit 4 set hands over: owner becomes firmware and message-valid becomes 1. Owner 1 without bit 4, or owner 2 or 3, changes nothing.
- R7: With the owner host, a control write of owner 0 releases the mailbox: owner none, message-valid 0.
- R8: While the owner is firmware, or while the owner is none and the code written is not 2, a host control write leaves owner and message-valid unchanged.
- R9: `fw_irq` is high exactly while message-valid is set. A `fw_release` pulse while firmware owns the mailbox sets owner to host and clears message-valid. In any other state it has no effect.
- R10: Host index `NUM_WORDS+1` reads the same value as the control word. Writes to it, and to indices above it, change nothing. Reads of indices above it return 0.
- R11: `fw_rdata` returns the data word selected by `fw_addr`, and the owner field never holds the reserved code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word index |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Host read data, combinational from host_addr |
| fw_claim | input | 1 | Firmware claims an unowned mailbox |
| fw_release | input | 1 | Firmware returns the mailbox to the host |
| fw_addr | input | IDX_W | Firmware data word index |
| fw_rdata | output | WORD_W | Data word selected by fw_addr |
| fw_irq | output | 1 | Message-valid indication to firmware |

## Verification
The assertions check the following on every cycle:
- The owner code stays legal.
- Message-valid is only ever seen together with firmware ownership.
- The data area never changes while the host does not own it.
- Handover, release, firmware claim and dropped-write busy each land on the cycle after their trigger.

Some behaviours need the bench's scenarios:
- A sweep of every owner code and valid bit from each of the three owner states covers the refused and ignored control writes.
- Data read-back patterns, the read-only copy, unmapped indices and the same-cycle claim race are also exercised only there.

// File: rtl/hfmb_pkg.sv
package hfmb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_FW   = 2'd1,
    OWN_HOST = 2'd2,
    OWN_RSVD = 2'd3
  } owner_e;

  localparam int CTL_W         = 8;
  localparam int CTL_OWN_LSB   = 0;
  localparam int CTL_VALID_BIT = 4;
  localparam int CTL_BUSY_BIT  = 5;

  function automatic logic [CTL_W-1:0] ctl_pack(input owner_e own, input logic vld,
                                                input logic busy);
    logic [CTL_W-1:0] w;
    w = '0;
    w[CTL_OWN_LSB +: 2] = own;
    w[CTL_VALID_BIT]    = vld;
    w[CTL_BUSY_BIT]     = busy;
    return w;
  endfunction

  function automatic owner_e ctl_owner(input logic [CTL_W-1:0] w);
    return owner_e'(w[CTL_OWN_LSB +: 2]);
  endfunction

  function automatic logic ctl_valid(input logic [CTL_W-1:0] w);
    return w[CTL_VALID_BIT];
  endfunction

  function automatic logic ctl_busy_clr(input logic [CTL_W-1:0] w);
    return w[CTL_BUSY_BIT];
  endfunction

endpackage

// File: rtl/hfmb_decode.sv
module hfmb_decode #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 4,
  parameter int IDX_W     = 3
) (
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              data_wr,
  output logic              ctrl_wr,
  output logic              data_sel,
  output logic              ctl_sel,
  output logic [IDX_W-1:0]  word_idx
);
  localparam logic [ADDR_W-1:0] CTL_IDX = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] SHD_IDX = ADDR_W'(NUM_WORDS + 1);

  always_comb begin
    data_sel = host_addr < CTL_IDX;
    ctl_sel  = (host_addr == CTL_IDX) || (host_addr == SHD_IDX);
    data_wr  = host_we && data_sel;
    ctrl_wr  = host_we && (host_addr == CTL_IDX);
    word_idx = host_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/hfmb_own_fsm.sv
module hfmb_own_fsm
  import hfmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [CTL_W-1:0] ctl_wbits,
  input  logic             data_wr,
  input  logic             fw_claim,
  input  logic             fw_release,
  output owner_e           owner,
  output logic             msg_valid,
  output logic             busy,
  output logic             host_owns
);
  owner_e owner_d;
  logic   valid_d, busy_d;
  owner_e w_own;
  logic   w_vld;

  assign w_own     = ctl_owner(ctl_wbits);
  assign w_vld     = ctl_valid(ctl_wbits);
  assign host_owns = (owner == OWN_HOST);

  always_comb begin
    owner_d = owner;
    valid_d = msg_valid;
    busy_d  = busy;
    if (ctrl_wr && ctl_busy_clr(ctl_wbits)) busy_d = 1'b0;
    if (data_wr && !host_owns) busy_d = 1'b1;
    unique case (owner)
      OWN_NONE: begin
        if (fw_claim) owner_d = OWN_FW;
        else if (ctrl_wr && w_own == OWN_HOST) owner_d = OWN_HOST;
      end
      OWN_HOST: begin
        if (ctrl_wr) begin
          if (w_own == OWN_FW && w_vld) begin
            owner_d = OWN_FW;
            valid_d = 1'b1;
          end else if (w_own == OWN_NONE) begin
            owner_d = OWN_NONE;
            valid_d = 1'b0;
          end
        end
      end
      OWN_FW: begin
        if (fw_release) begin
          owner_d = OWN_HOST;
          valid_d = 1'b0;
        end
      end
      default: begin
        owner_d = OWN_NONE;
        valid_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner     <= OWN_NONE;
      msg_valid <= 1'b0;
      busy      <= 1'b0;
    end else begin
      owner     <= owner_d;
      msg_valid <= valid_d;
      busy      <= busy_d;
    end
  end

  AST_OWNER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    owner != OWN_RSVD); // R11
  AST_VALID_IMPLIES_FW: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> owner == OWN_FW); // R9
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && owner == OWN_HOST && w_own == OWN_FW && w_vld)
      |=> (owner == OWN_FW && msg_valid)); // R6
  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && owner == OWN_HOST && w_own == OWN_NONE)
      |=> (owner == OWN_NONE && !msg_valid)); // R7
  AST_FW_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_release && owner == OWN_FW) |=> (owner == OWN_HOST && !msg_valid)); // R9
  AST_FW_CLAIM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_claim && owner == OWN_NONE) |=> owner == OWN_FW); // R5
  AST_BUSY_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && owner != OWN_HOST) |=> busy); // R3
  AST_FW_OWNED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_FW && !fw_release) |=> owner == OWN_FW); // R8
endmodule

// File: rtl/hfmb_store.sv
module hfmb_store #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 64,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        data_wr,
  input  logic                        allow,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [NUM_WORDS*WORD_W-1:0] words_flat
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              wen;
    assign wen = data_wr && allow && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   word_q <= '0;
      else if (wen) word_q <= wr_data;
    end
    assign words_flat[i*WORD_W +: WORD_W] = word_q;
  end

  AST_DATA_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> $stable(words_flat)); // R3
endmodule

// File: rtl/hfmb_top.sv
module hfmb_top
  import hfmb_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 64,
  parameter int ADDR_W    = $clog2(NUM_WORDS + 2),
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              fw_claim,
  input  logic              fw_release,
  input  logic [IDX_W-1:0]  fw_addr,
  output logic [WORD_W-1:0] fw_rdata,
  output logic              fw_irq
);
  logic                        data_wr, ctrl_wr, data_sel, ctl_sel;
  logic [IDX_W-1:0]            word_idx;
  owner_e                      owner;
  logic                        msg_valid, busy, host_owns;
  logic [NUM_WORDS*WORD_W-1:0] words_flat;
  logic [CTL_W-1:0]            ctl_word;

  hfmb_decode #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .host_we  (host_we),
    .host_addr(host_addr),
    .data_wr  (data_wr),
    .ctrl_wr  (ctrl_wr),
    .data_sel (data_sel),
    .ctl_sel  (ctl_sel),
    .word_idx (word_idx)
  );

  hfmb_own_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctl_wbits (host_wdata[CTL_W-1:0]),
    .data_wr   (data_wr),
    .fw_claim  (fw_claim),
    .fw_release(fw_release),
    .owner     (owner),
    .msg_valid (msg_valid),
    .busy      (busy),
    .host_owns (host_owns)
  );

  hfmb_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .allow     (host_owns),
    .wr_idx    (word_idx),
    .wr_data   (host_wdata),
    .words_flat(words_flat)
  );

  assign ctl_word = ctl_pack(owner, msg_valid, busy);
  assign fw_irq   = msg_valid;
  assign fw_rdata = words_flat[fw_addr*WORD_W +: WORD_W];

  always_comb begin
    host_rdata = '0;
    if (data_sel)     host_rdata = words_flat[word_idx*WORD_W +: WORD_W];
    else if (ctl_sel) host_rdata = {{(WORD_W-CTL_W){1'b0}}, ctl_word};
  end
endmodule

// File: tb/hfmb_top_tb.sv
module hfmb_top_tb;
  localparam int NW = 8;
  localparam int WW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [3:0]    host_addr = '0;
  logic [WW-1:0] host_wdata = '0;
  logic [WW-1:0] host_rdata;
  logic          fw_claim = 1'b0;
  logic          fw_release = 1'b0;
  logic [2:0]    fw_addr = '0;
  logic [WW-1:0] fw_rdata;
  logic          fw_irq;

  int tests = 0;
  int fails = 0;

  int            m_own = 0;
  bit            m_vld = 0;
  bit            m_busy = 0;
  logic [WW-1:0] m_data [NW];

  always #5 clk = ~clk;

  hfmb_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fw_claim(fw_claim),
    .fw_release(fw_release), .fw_addr(fw_addr), .fw_rdata(fw_rdata), .fw_irq(fw_irq)
  );

  function automatic logic [WW-1:0] exp_ctl();
    return WW'(m_own) | (WW'(m_vld) << 4) | (WW'(m_busy) << 5);
  endfunction

  function automatic logic [WW-1:0] pat(input int i);
    return 64'hC3A5_0000_0000_0000 ^ (64'(i + 1) * 64'h0001_0203_0405_0607);
  endfunction

  task automatic chk(input logic [WW-1:0] got, input logic [WW-1:0] exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [WW-1:0] v);
    host_addr = 4'(idx);
    #1 v = host_rdata;
  endtask

  task automatic step(input bit we, input int idx, input logic [WW-1:0] wd,
                      input bit claim, input bit rel);
    int o;
    @(negedge clk);
    host_we = we; host_addr = 4'(idx); host_wdata = wd;
    fw_claim = claim; fw_release = rel;
    o = int'(wd[1:0]);
    if (we && idx == NW && wd[5]) m_busy = 0;
    if (we && idx < NW) begin
      if (m_own == 2) m_data[idx] = wd;
      else m_busy = 1;
    end
    case (m_own)
      0: if (claim) m_own = 1;
         else if (we && idx == NW && o == 2) m_own = 2;
      2: if (we && idx == NW) begin
           if (o == 1 && wd[4]) begin m_own = 1; m_vld = 1; end
           else if (o == 0) begin m_own = 0; m_vld = 0; end
         end
      1: if (rel) begin m_own = 2; m_vld = 0; end
      default: ;
    endcase
    @(negedge clk);
    host_we = 0; fw_claim = 0; fw_release = 0;
  endtask

  task automatic ctl_write(input int v);
    step(1, NW, WW'(v), 0, 0);
  endtask

  task automatic check_ctl(input string req);
    logic [WW-1:0] v;
    rd(NW, v);     chk(v, exp_ctl(), req);
    rd(NW + 1, v); chk(v, exp_ctl(), "R10 shadow");
  endtask

  task automatic goto_state(input int s);
    if (m_own == 1) step(0, 0, '0, 0, 1);
    if (m_own == 2) ctl_write(32'h20);
    else ctl_write(32'h20);
    if (s == 2) ctl_write(2);
    if (s == 1) step(0, 0, '0, 1, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [WW-1:0] v;
    for (int i = 0; i < NW; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check_ctl("R1 ctrl");
    for (int i = 0; i < NW; i++) begin rd(i, v); chk(v, '0, "R1 data"); end
    chk(WW'(fw_irq), '0, "R1 irq");

    // R3 data write while unowned is dropped, busy set
    step(1, 2, 64'h1234, 0, 0);
    rd(2, v); chk(v, '0, "R3 dropped");
    check_ctl("R3 busy");
    // R4 clear busy
    ctl_write(32'h20);
    check_ctl("R4 clear");

    // R5 R6 R7 R8 sweep of every owner code and valid bit from each state
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 8; c++) begin
        goto_state(s);
        ctl_write((c & 3) | ((c >> 2) << 4));
        check_ctl("R5_R6_R7_R8 sweep");
        chk(WW'(fw_irq), WW'(m_vld), "R9 irq");
      end
    end

    // R2 R11 fill and read back all words
    goto_state(2);
    for (int i = 0; i < NW; i++) step(1, i, pat(i), 0, 0);
    for (int i = 0; i < NW; i++) begin
      rd(i, v); chk(v, pat(i), "R2 readback");
      fw_addr = 3'(i); #1 chk(fw_rdata, pat(i), "R11 fw read");
    end

    // R6 handover, then R3 protection under firmware ownership
    ctl_write(32'h11);
    check_ctl("R6 handover");
    chk(WW'(fw_irq), 1, "R9 irq high");
    step(1, 5, 64'hDEAD, 0, 0);
    rd(5, v); chk(v, pat(5), "R3 fw-owned drop");
    check_ctl("R3 busy fw");
    ctl_write(32'h22);
    check_ctl("R8 fw locked");

    // R9 firmware return
    step(0, 0, '0, 0, 1);
    check_ctl("R9 release");
    chk(WW'(fw_irq), 0, "R9 irq low");
    step(0, 0, '0, 0, 1);
    check_ctl("R9 release ignored");

    // R5 simultaneous claim: firmware wins
    ctl_write(32'h20);
    step(1, NW, 64'h2, 1, 0);
    check_ctl("R5 race");

    // R10 shadow and unmapped writes ignored
    step(0, 0, '0, 0, 1);
    step(1, NW + 1, 64'h11, 0, 0);
    check_ctl("R10 shadow write");
    for (int a = NW + 2; a < 16; a++) begin
      step(1, a, 64'hFFFF, 0, 0);
      rd(a, v); chk(v, '0, "R10 unmapped");
    end
    check_ctl("R10 unmapped ctrl");
    for (int i = 0; i < NW; i++) begin rd(i, v); chk(v, m_data[i], "R10 data intact"); end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule